// File: doc/BRIEF.md
# Dual-Processor Interrupt Router

This block steers 64 level-sensitive interrupt sources onto a handful of interrupt request lines for each of two processors. Every processor owns a private register bank: a mask with one bit per source, a small route register per source that picks one of its request lines, a 64-bit mailbox that processors use to signal each other, and a 64-bit pending register that captures one-cycle hit pulses from a bus bridge. The two banks share nothing except the source inputs, so one source may be enabled on one processor and masked on the other, or routed to different lines on each.

Software reaches both banks through a simple register bus with a 64-bit data path. Address bit 11 picks the processor bank, and the remaining bits pick a register inside it. A write takes effect on the clock edge where it is presented. A read returns its data one cycle later, together with a valid flag. The request lines are combinational from the bank state and the source inputs, and processors sample them on their next clock.

Read responses come from a two-state bus sequencer. In BUS_IDLE no response is shown. A read request moves it to BUS_RESP (transition IDLE to RESP), where the captured data is presented with the valid flag. Further back-to-back reads keep it in BUS_RESP (RESP to RESP). A cycle with no read returns it to BUS_IDLE (RESP to IDLE).

Top module: `intr_router`

## Requirements
- R1: After reset every mask bit is 1, every route register is 0, the mailbox and pending registers of both banks are 0, and all request lines are low.
- R2: The mask register sits at byte offset 0x000 of a bank. A mask bit of 1 blocks its source from every request line of that bank, and a 0 lets the source through.
- R3: The route register of source i sits at byte offset 0x400 + 8*i and stores the low 3 bits of the written data. A value v from 0 to 4 steers the source to request line v of that bank. Values 5 to 7 steer it to no line. A read returns the stored value zero-extended.
- R4: Request line v of a bank is high, in the same cycle, exactly when at least one source is active, unmasked in that bank and routed to v. For processor p, line v is bit p*5+v of irq_req.
- R5: Bus address bit 11 selects the bank (0 or 1). A write to one bank leaves every register and request line of the other bank unchanged.
- R6: The mailbox reads at offset 0x008. Ones written to offset 0x010 set the matching mailbox bits. Ones written to offset 0x018 clear the matching bits. Zero bits in either write leave the mailbox bits unchanged.
- R7: In each bank, source 26 is active when any of mailbox bits 63..48 is 1, in place of irq_src[26] and pending bit 26. Mailbox bits 47..0 raise no interrupt.
- R8: A 1 on bridge_hit[i] sets pending bit i in both banks at the next clock edge. The pending register reads at offset 0x020. A set pending bit i makes source i active in that bank, in addition to irq_src[i].
- R9: Ones written to offset 0x028 clear the matching pending bits of the addressed bank only. Zero bits have no effect. A bridge_hit bit high in the same cycle as a clear of that bit leaves the bit set.
- R10: A read request gives bus_rvalid high with the data in the next cycle. bus_rvalid is low in the cycle after a cycle with no read. Reads of write-only ports (0x010, 0x018, 0x028), of unmapped offsets, and of any address whose low three bits are not zero return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address; bit 11 selects the bank |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd |
| irq_src | input | 64 | Level interrupt sources |
| bridge_hit | input | 64 | Bridged interrupt hit pulses, one bit per source |
| irq_req | output | 10 | Request lines, bit p*5+v is line v of processor p |

## Verification
The assertions assume the bridge and the bus master behave as independent agents. A clear of the pending register is only checked for having emptied bits in cycles where bridge_hit is all zero. The mailbox clear check assumes the write carries all ones and is the only write in that cycle, and the single bus port guarantees this. The stimulus drives bridge_hit as isolated one-cycle pulses, except for one deliberate collision with a pending clear. It issues at most one bus access per cycle, and it keeps irq_src[26] low, so the mailbox alone decides source 26.

// File: rtl/irtr_pkg.sv
package irtr_pkg;

    // word offsets (byte offset / 8) inside one processor bank
    localparam int OFS_MASK     = 0;
    localparam int OFS_MBOX     = 1;
    localparam int OFS_MSET     = 2;
    localparam int OFS_MCLR     = 3;
    localparam int OFS_PEND     = 4;
    localparam int OFS_PCLR     = 5;
    localparam int ROUTE_BASE_W = 128;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irtr_line_map.sv
module irtr_line_map #(
    parameter int NSRC = 64,
    parameter int NOUT = 5,
    parameter int RW   = 3
) (
    input  logic [NSRC-1:0]    act,
    input  logic [NSRC-1:0]    mask,
    input  logic [NSRC*RW-1:0] route_flat,
    output logic [NOUT-1:0]    lines
);

    for (genvar l = 0; l < NOUT; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
                if (act[i] && !mask[i] && (route_flat[i*RW +: RW] == RW'(l))) begin
                    hit = 1'b1;
                end
            end
        end
        assign lines[l] = hit;
    end

endmodule

// File: rtl/irtr_cpu_bank.sv
module irtr_cpu_bank
    import irtr_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int NOUT     = 5,
    parameter int RW       = 3,
    parameter int WW       = 8,
    parameter int MBOX_SRC = 26,
    parameter int MBOX_HI  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WW-1:0]   word,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] irq_src,
    input  logic [NSRC-1:0] bridge_hit,
    output logic [NSRC-1:0] rd_val,
    output logic [NOUT-1:0] lines,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] mbox_o,
    output logic [NSRC-1:0] pend_o
);

    logic [NSRC-1:0]    mask_q;
    logic [NSRC-1:0]    mbox_q;
    logic [NSRC-1:0]    pend_q;
    logic [RW-1:0]      route_q [NSRC];
    logic [NSRC*RW-1:0] route_flat;
    logic [NSRC-1:0]    act;
    logic [NSRC-1:0]    mset_bits;
    logic [NSRC-1:0]    mclr_bits;
    logic [NSRC-1:0]    pclr_bits;

    assign mset_bits = (wr_en && word == WW'(OFS_MSET)) ? wdata : '0;
    assign mclr_bits = (wr_en && word == WW'(OFS_MCLR)) ? wdata : '0;
    assign pclr_bits = (wr_en && word == WW'(OFS_PCLR)) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && word == WW'(OFS_MASK)) begin
            mask_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mbox_q <= '0;
        end else begin
            mbox_q <= (mbox_q & ~mclr_bits) | mset_bits;
        end
    end

    // a bridge hit outranks a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~pclr_bits) | bridge_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                route_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NSRC; i++) begin
                if (word == WW'(ROUTE_BASE_W + i)) begin
                    route_q[i] <= wdata[RW-1:0];
                end
            end
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flat
        assign route_flat[i*RW +: RW] = route_q[i];
    end

    always_comb begin
        act           = irq_src | pend_q;
        act[MBOX_SRC] = |mbox_q[NSRC-1 -: MBOX_HI];
    end

    always_comb begin
        rd_val = '0;
        if (word == WW'(OFS_MASK)) begin
            rd_val = mask_q;
        end else if (word == WW'(OFS_MBOX)) begin
            rd_val = mbox_q;
        end else if (word == WW'(OFS_PEND)) begin
            rd_val = pend_q;
        end
        for (int i = 0; i < NSRC; i++) begin
            if (word == WW'(ROUTE_BASE_W + i)) begin
                rd_val = {{(NSRC-RW){1'b0}}, route_q[i]};
            end
        end
    end

    irtr_line_map #(
        .NSRC (NSRC),
        .NOUT (NOUT),
        .RW   (RW)
    ) u_map (
        .act        (act),
        .mask       (mask_q),
        .route_flat (route_flat),
        .lines      (lines)
    );

    assign mask_o = mask_q;
    assign mbox_o = mbox_q;
    assign pend_o = pend_q;

endmodule

// File: rtl/irtr_bus_fsm.sv
module irtr_bus_fsm
    import irtr_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [DW-1:0] rd_val,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    bus_state_e    state_q;
    bus_state_e    state_d;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd)  state_d = BUS_RESP;
            BUS_RESP: if (!rd) state_d = BUS_IDLE;
            default:           state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd) begin
            data_q <= rd_val;
        end
    end

    always_comb begin
        rvalid = (state_q == BUS_RESP);
        rdata  = data_q;
    end

endmodule

// File: rtl/intr_router.sv
module intr_router
    import irtr_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int NOUT     = 5,
    parameter int NCPU     = 2,
    parameter int AW       = 12,
    parameter int MBOX_SRC = 26,
    parameter int MBOX_HI  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [AW-1:0]        bus_addr,
    input  logic [NSRC-1:0]      bus_wdata,
    output logic [NSRC-1:0]      bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NSRC-1:0]      irq_src,
    input  logic [NSRC-1:0]      bridge_hit,
    output logic [NCPU*NOUT-1:0] irq_req
);

    localparam int CB = (NCPU > 1) ? $clog2(NCPU) : 1;
    localparam int WW = AW - CB - 3;
    localparam int RW = $clog2(NOUT + 1);

    logic [CB-1:0]        cpu_sel;
    logic [WW-1:0]        word;
    logic                 aligned;
    logic [NCPU*NSRC-1:0] rd_flat;
    logic [NCPU*NSRC-1:0] mask_flat;
    logic [NCPU*NSRC-1:0] mbox_flat;
    logic [NCPU*NSRC-1:0] pend_flat;
    logic [NSRC-1:0]      rd_mux;

    assign cpu_sel = bus_addr[AW-1 -: CB];
    assign word    = bus_addr[3 +: WW];
    assign aligned = (bus_addr[2:0] == 3'b000);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irtr_cpu_bank #(
            .NSRC     (NSRC),
            .NOUT     (NOUT),
            .RW       (RW),
            .WW       (WW),
            .MBOX_SRC (MBOX_SRC),
            .MBOX_HI  (MBOX_HI)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bus_wr && aligned && (cpu_sel == CB'(c))),
            .word       (word),
            .wdata      (bus_wdata),
            .irq_src    (irq_src),
            .bridge_hit (bridge_hit),
            .rd_val     (rd_flat[c*NSRC +: NSRC]),
            .lines      (irq_req[c*NOUT +: NOUT]),
            .mask_o     (mask_flat[c*NSRC +: NSRC]),
            .mbox_o     (mbox_flat[c*NSRC +: NSRC]),
            .pend_o     (pend_flat[c*NSRC +: NSRC])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (aligned && cpu_sel == CB'(c)) begin
                rd_mux = rd_flat[c*NSRC +: NSRC];
            end
        end
    end

    irtr_bus_fsm #(
        .DW (NSRC)
    ) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (bus_rd),
        .rd_val (rd_mux),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk
    import irtr_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NOUT = 5,
    parameter int NCPU = 2,
    parameter int AW   = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [AW-1:0]        bus_addr,
    input logic [NSRC-1:0]      bus_wdata,
    input logic                 bus_rvalid,
    input logic [NSRC-1:0]      bridge_hit,
    input logic [NCPU*NOUT-1:0] irq_req,
    input logic [NCPU*NSRC-1:0] mask_flat,
    input logic [NCPU*NSRC-1:0] mbox_flat,
    input logic [NCPU*NSRC-1:0] pend_flat
);

    localparam int CB = (NCPU > 1) ? $clog2(NCPU) : 1;
    localparam int WW = AW - CB - 3;

    p_rvalid_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    p_rvalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    for (genvar k = 0; k < NCPU; k++) begin : g_chk
        p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (&mask_flat[k*NSRC +: NSRC]) |-> (irq_req[k*NOUT +: NOUT] == '0));

        p_mbox_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == {CB'(k), WW'(OFS_MCLR), 3'b000}) && (&bus_wdata))
            |=> (mbox_flat[k*NSRC +: NSRC] == '0));

        p_pend_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bridge_hit != '0)
            |=> ((pend_flat[k*NSRC +: NSRC] & $past(bridge_hit)) == $past(bridge_hit)));

        p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == {CB'(k), WW'(OFS_PCLR), 3'b000}) && (bridge_hit == '0))
            |=> ((pend_flat[k*NSRC +: NSRC] & $past(bus_wdata)) == '0));
    end

endmodule

bind intr_router intr_router_chk #(
    .NSRC (NSRC),
    .NOUT (NOUT),
    .NCPU (NCPU),
    .AW   (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bridge_hit (bridge_hit),
    .irq_req    (irq_req),
    .mask_flat  (mask_flat),
    .mbox_flat  (mbox_flat),
    .pend_flat  (pend_flat)
);

// File: tb/tb_intr_router.sv
`timescale 1ns/1ps
module tb_intr_router;

    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic [63:0] irq_src = '0;
    logic [63:0] bridge_hit = '0;
    logic [9:0]  irq_req;

    always #2.5 clk = ~clk;

    intr_router dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_src    (irq_src),
        .bridge_hit (bridge_hit),
        .irq_req    (irq_req)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic [63:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ra(int cpu, int ofs);
        return AW'((cpu << 11) | ofs);
    endfunction

    task automatic bwr(int cpu, int ofs, logic [63:0] d);
        bus_wr    = 1'b1;
        bus_addr  = ra(cpu, ofs);
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // driver: queue the expected response, then issue the read
    task automatic brd(int cpu, int ofs, logic [63:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_rd   = 1'b1;
        bus_addr = ra(cpu, ofs);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic chk_irq(string tag, logic [9:0] e);
        #1;
        chk(tag, 64'(irq_req), 64'(e));
    endtask

    // monitor: compare each read response with the queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 unexpected response actual=1 expected=0");
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_irq("R1 lines low in reset", 10'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_irq("R1 lines low after reset", 10'd0);
        brd(0, 'h000, '1, "R1 mask cpu0 all ones");
        brd(1, 'h000, '1, "R1 mask cpu1 all ones");
        brd(1, 'h448, 64'd0, "R1 route cpu1 src9 zero");
        brd(0, 'h008, 64'd0, "R1 mailbox cpu0 zero");
        brd(1, 'h020, 64'd0, "R1 pending cpu1 zero");
        @(negedge clk);
        chk("R10 rvalid low when idle", 64'(bus_rvalid), 64'd0);

        // R2 R4: cpu0 source 3 to line 2
        bwr(0, 'h418, 64'd2);
        bwr(0, 'h000, ~(64'd1 << 3));
        irq_src[3] = 1'b1;
        chk_irq("R4 cpu0 src3 on line2", 10'b00000_00100);
        chk_irq("R5 cpu1 untouched", 10'b00000_00100);

        // R5: cpu1 gets its own route for source 3
        bwr(1, 'h418, 64'd0);
        bwr(1, 'h000, ~(64'd1 << 3));
        chk_irq("R5 both cpus differ", 10'b00001_00100);
        brd(0, 'h418, 64'd2, "R5 cpu0 route kept");

        // R2: mask again on cpu0
        bwr(0, 'h000, '1);
        chk_irq("R2 cpu0 masked", 10'b00001_00000);

        // R3: every route value on cpu1
        for (int v = 0; v < 8; v++) begin
            bwr(1, 'h418, 64'hFFFF_FFFF_FFFF_FFF8 | 64'(v));
            chk_irq($sformatf("R3 route value %0d", v),
                    (v < 5) ? 10'(1 << (5 + v)) : 10'd0);
            brd(1, 'h418, 64'(v), $sformatf("R3 route readback %0d", v));
        end
        bwr(1, 'h418, 64'd1);
        chk_irq("R4 cpu1 line1", 10'b00010_00000);
        irq_src[3] = 1'b0;
        chk_irq("R4 inactive source drops", 10'd0);

        // R6 R7: mailbox of cpu1
        bwr(1, 'h000, ~(64'd1 << 26));
        bwr(1, 'h4D0, 64'd4);
        bwr(1, 'h010, 64'd1 << 10);
        chk_irq("R7 low mailbox bit silent", 10'd0);
        brd(1, 'h008, 64'd1 << 10, "R6 mailbox set bit10");
        bwr(1, 'h010, 64'd1 << 50);
        chk_irq("R7 high mailbox bit raises line4", 10'b10000_00000);
        brd(1, 'h008, (64'd1 << 10) | (64'd1 << 50), "R6 mailbox set keeps old");
        brd(0, 'h008, 64'd0, "R5 cpu0 mailbox empty");
        brd(1, 'h010, 64'd0, "R10 set port reads zero");
        bwr(1, 'h018, 64'd1 << 10);
        brd(1, 'h008, 64'd1 << 50, "R6 clear one bit");
        chk_irq("R7 line4 still high", 10'b10000_00000);
        bwr(1, 'h018, '1);
        brd(1, 'h008, 64'd0, "R6 clear all");
        chk_irq("R7 line4 drops", 10'd0);

        // R8 R9: pending
        bwr(0, 'h000, ~(64'd1 << 40));
        bwr(0, 'h540, 64'd1);
        bridge_hit[40] = 1'b1;
        @(negedge clk);
        bridge_hit[40] = 1'b0;
        chk_irq("R8 pending src40 line1", 10'b00000_00010);
        brd(0, 'h020, 64'd1 << 40, "R8 pending cpu0");
        brd(1, 'h020, 64'd1 << 40, "R8 pending cpu1");
        bwr(0, 'h028, 64'd0);
        brd(0, 'h020, 64'd1 << 40, "R9 clear zeros no effect");
        bwr(0, 'h028, 64'd1 << 40);
        brd(0, 'h020, 64'd0, "R9 cpu0 cleared");
        chk_irq("R9 line1 drops", 10'd0);
        brd(1, 'h020, 64'd1 << 40, "R9 cpu1 keeps pending");
        bridge_hit[40] = 1'b1;
        bwr(1, 'h028, 64'd1 << 40);
        bridge_hit[40] = 1'b0;
        brd(1, 'h020, 64'd1 << 40, "R9 hit wins over clear");
        bwr(1, 'h028, 64'd1 << 40);
        brd(1, 'h020, 64'd0, "R9 cpu1 cleared");

        // R10: unmapped and misaligned reads
        brd(0, 'h100, 64'd0, "R10 unmapped offset");
        brd(0, 'h7F8, 64'd0, "R10 top offset");
        brd(0, 'h028, 64'd0, "R10 pending clear port reads zero");
        brd(0, 'h004, 64'd0, "R10 misaligned mask read");
        brd(0, 'h540, 64'd1, "R3 route src40 readback");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule